// File: doc/BRIEF.md
# Latched-Address Complementing Scratchpad RAM

This block is a small synchronous scratchpad memory of 16 words, 4 bits each. All control is active low. A select input opens an access window. A write input chooses between storing and reading inside that window. Every input is sampled on the rising edge of one system clock.

The word address is captured only at the moment the select input is first seen low after being high. From then on the address inputs may wander freely until the select input is released. Reads return the bitwise inverse of the stored word. In place of a three-state driver, a registered output-enable flag marks when the data output carries read data. While that flag is low, the data output is forced to zero.

A single select window may hold a read followed by a write to the same word, which gives a read-modify-write cycle without a second address capture. The output side has no back-pressure. Read data is valid for exactly the cycles in which the enable flag is high, and a consumer must take it then.

Top module: `cscratch_ram`

## Requirements
- R1: The array holds 16 independent 4-bit words, addressed by the 4-bit binary value on `addr_in`. Each word can be written and read back without disturbing the others.
- R2: The address register loads `addr_in` on the first clock edge at which `sel_n` is sampled low after being sampled high. Later changes of `addr_in` while `sel_n` stays low do not change the selected word.
- R3: Keeping `sel_n` low over many cycles never captures a new address. A new address takes effect only after `sel_n` is seen high and then low again.
- R4: On every clock edge where `sel_n` and `wr_n` are both low, `din` is stored into the selected word. That word is the one captured on that same edge if it is the capturing edge. Repeated such edges overwrite the word with the current `din`.
- R5: On a clock edge with `sel_n` low and `wr_n` high, the bitwise complement of the selected word appears on `dout`. Reading any number of times leaves the stored word unchanged.
- R6: `dout_en` is low, and `dout` equals 4'b0000, in any cycle that follows an edge where `sel_n` was high or `wr_n` was low.
- R7: Within one low period of `sel_n`, a read (with `wr_n` high) followed by a write (with `wr_n` low) acts on the same word. A later read in that period returns the complement of the newly written value.
- R8: `dout` and `dout_en` are registered. They reflect the inputs sampled on the preceding rising edge, with one cycle of latency.
- R9: A synchronous active-high `rst` clears the address register, sets the select history to "deselected" and drives `dout_en` low and `dout` to zero. Memory contents are left undefined. The first low `sel_n` after reset captures an address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Memory select, active low; its high-to-low change captures the address |
| wr_n | input | 1 | Write control, active low; high means read |
| addr_in | input | 4 | Word address, used on the capturing edge |
| din | input | 4 | Write data |
| dout | output | 4 | Complement of the selected word during a read, zero otherwise |
| dout_en | output | 1 | High when `dout` carries read data (stands in for three-state enable) |

## Verification
The bound checker watches the output-enable rules on every cycle. It checks that the flag drops after any deselected or writing cycle and rises after any reading cycle. It checks that a disabled output is zero and that reset leaves the output off. It also checks that a held read inside one select window keeps `dout` steady. Address capture, where writes land, the read-modify-write ordering and the stored values themselves need knowledge of what was written earlier. Only the bench's directed scenarios can show these, by comparing read data against its own model of the 16 words.

// File: rtl/cram_pkg.sv
package cram_pkg;
  parameter int CRAM_AW = 4;
  parameter int CRAM_DW = 4;

  typedef enum logic [1:0] {
    CRAM_IDLE  = 2'd0,
    CRAM_READ  = 2'd1,
    CRAM_WRITE = 2'd2
  } cram_op_e;
endpackage

// File: rtl/cram_addr_latch.sv
module cram_addr_latch #(
  parameter int AW = cram_pkg::CRAM_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic [AW-1:0]     addr_in,
  output logic [AW-1:0]     word_sel,
  output cram_pkg::cram_op_e op
);
  logic          sel_hist;   // sel_n as sampled one edge earlier
  logic [AW-1:0] addr_q;
  logic          open_edge;

  assign open_edge = sel_hist & ~sel_n;
  // On the capturing edge the new address is already in force.
  assign word_sel  = open_edge ? addr_in : addr_q;

  always_comb begin
    if (sel_n)      op = cram_pkg::CRAM_IDLE;
    else if (wr_n)  op = cram_pkg::CRAM_READ;
    else            op = cram_pkg::CRAM_WRITE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_hist <= 1'b1;
      addr_q   <= '0;
    end else begin
      sel_hist <= sel_n;
      if (open_edge) addr_q <= addr_in;
    end
  end
endmodule

// File: rtl/cram_array.sv
module cram_array #(
  parameter int AW = cram_pkg::CRAM_AW,
  parameter int DW = cram_pkg::CRAM_DW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (we && (idx == AW'(w))) cells[w] <= wdata;
    end
  end

  assign rdata = cells[idx];
endmodule

// File: rtl/cram_rdport.sv
module cram_rdport #(
  parameter int DW = cram_pkg::CRAM_DW
) (
  input  logic               clk,
  input  logic               rst,
  input  cram_pkg::cram_op_e op,
  input  logic [DW-1:0]      word,
  output logic [DW-1:0]      dout,
  output logic               dout_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else if (op == cram_pkg::CRAM_READ) begin
      dout    <= ~word;
      dout_en <= 1'b1;
    end else begin
      dout    <= '0;
      dout_en <= 1'b0;
    end
  end
endmodule

// File: rtl/cscratch_ram.sv
module cscratch_ram #(
  parameter int AW = cram_pkg::CRAM_AW,
  parameter int DW = cram_pkg::CRAM_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en
);
  logic [AW-1:0]      word_sel;
  logic [DW-1:0]      word_q;
  cram_pkg::cram_op_e op;
  logic               do_write;

  cram_addr_latch #(.AW(AW)) u_latch (
    .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n),
    .addr_in(addr_in), .word_sel(word_sel), .op(op)
  );

  assign do_write = (op == cram_pkg::CRAM_WRITE) && !rst;

  cram_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .we(do_write), .idx(word_sel), .wdata(din), .rdata(word_q)
  );

  cram_rdport #(.DW(DW)) u_rdport (
    .clk(clk), .rst(rst), .op(op), .word(word_q),
    .dout(dout), .dout_en(dout_en)
  );
endmodule

// File: rtl/cscratch_ram_chk.sv
module cscratch_ram_chk #(
  parameter int DW = cram_pkg::CRAM_DW
) (
  input logic          clk,
  input logic          rst,
  input logic          sel_n,
  input logic          wr_n,
  input logic [DW-1:0] dout,
  input logic          dout_en
);
  AST_OFF_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
    (sel_n || !wr_n) |=> !dout_en); // R6

  AST_ON_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && wr_n) |=> dout_en); // R8

  AST_ZERO_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !dout_en |-> (dout == '0)); // R6

  AST_HELD_READ_STABLE: assert property (@(posedge clk) disable iff (rst)
    (dout_en && !sel_n && wr_n) |=> $stable(dout)); // R5

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!dout_en && dout == '0)); // R9
endmodule

bind cscratch_ram cscratch_ram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n),
  .dout(dout), .dout_en(dout_en)
);

// File: tb/tb_cscratch_ram.sv
module tb_cscratch_ram;
  logic       clk = 1'b0;
  logic       rst;
  logic       sel_n, wr_n;
  logic [3:0] addr_in, din;
  logic [3:0] dout;
  logic       dout_en;

  logic [3:0] model [16];
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cscratch_ram dut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n),
    .addr_in(addr_in), .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual {en,dout}=%b expected %b", req, act, exp);
    end
  endtask

  // Apply inputs at a falling edge, return at the next falling edge,
  // where outputs show the result of the rising edge in between.
  task automatic step(input logic s, input logic w, input logic [3:0] a, input logic [3:0] d);
    sel_n = s; wr_n = w; addr_in = a; din = d;
    @(negedge clk);
  endtask

  task automatic write_word(input logic [3:0] a, input logic [3:0] d);
    step(1, 1, a, 4'h0);
    step(0, 0, a, d);
    check("R6 write keeps output off", {dout_en, dout}, 5'b0);
    model[a] = d;
    step(1, 1, 4'h0, 4'h0);
  endtask

  task automatic read_word(input string req, input logic [3:0] a);
    logic [3:0] e;
    e = ~model[a];
    step(1, 1, a, 4'h0);
    step(0, 1, a, 4'h0);
    check(req, {dout_en, dout}, {1'b1, e});
    step(1, 1, 4'h0, 4'h0);
    check("R6 deselect turns output off", {dout_en, dout}, 5'b0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(1, 1, 4'h0, 4'h0);
    step(0, 1, 4'h5, 4'h0);
    check("R9 reset output off", {dout_en, dout}, 5'b0);
    rst = 1'b0;
    step(1, 1, 4'h0, 4'h0);
    check("R9 after reset idle", {dout_en, dout}, 5'b0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 16; i++) write_word(4'(i), 4'((i * 5 + 3) & 15));
    for (int i = 0; i < 16; i++) read_word("R1 R5 R8 read each word", 4'(i));
  endtask

  task automatic t_addr_hold();
    logic [3:0] e;
    e = ~model[3];
    step(1, 1, 4'h3, 4'h0);
    step(0, 1, 4'h3, 4'h0);
    check("R2 read captured word", {dout_en, dout}, {1'b1, e});
    step(0, 1, 4'h9, 4'h0);
    check("R2 address change ignored", {dout_en, dout}, {1'b1, e});
    step(0, 1, 4'hC, 4'h0);
    check("R5 repeated read unchanged", {dout_en, dout}, {1'b1, e});
    step(1, 1, 4'h0, 4'h0);
  endtask

  task automatic t_no_relatch();
    step(1, 1, 4'h3, 4'h0);
    step(0, 1, 4'h3, 4'h0);
    step(0, 1, 4'h9, 4'h0);
    step(0, 0, 4'h9, 4'hA);   // lands on word 3
    model[3] = 4'hA;
    step(1, 1, 4'h0, 4'h0);
    read_word("R3 held select wrote captured word", 4'h3);
    read_word("R3 other word untouched", 4'h9);
  endtask

  task automatic t_rewrite();
    step(1, 1, 4'h6, 4'h0);
    step(0, 0, 4'h6, 4'h1);   // capture and write on the same edge
    step(0, 0, 4'h2, 4'h7);
    step(0, 0, 4'hF, 4'h4);
    check("R4 repeated write output off", {dout_en, dout}, 5'b0);
    model[6] = 4'h4;
    step(1, 1, 4'h0, 4'h0);
    read_word("R4 last write wins", 4'h6);
    read_word("R4 word 2 untouched", 4'h2);
    read_word("R4 word 15 untouched", 4'hF);
  endtask

  task automatic t_rmw();
    logic [3:0] e;
    e = ~model[11];
    step(1, 1, 4'hB, 4'h0);
    step(0, 1, 4'hB, 4'h0);
    check("R7 first read", {dout_en, dout}, {1'b1, e});
    step(0, 0, 4'h1, 4'h5);
    check("R7 write phase output off", {dout_en, dout}, 5'b0);
    model[11] = 4'h5;
    step(0, 1, 4'h1, 4'h0);
    check("R7 read back new value", {dout_en, dout}, {1'b1, 4'hA});
    step(1, 1, 4'h0, 4'h0);
    read_word("R7 word 1 untouched", 4'h1);
  endtask

  task automatic t_reset_reopen();
    rst = 1'b1;
    step(0, 1, 4'h2, 4'h0);
    rst = 1'b0;
    step(0, 1, 4'hB, 4'h0);   // first low after reset captures 11
    check("R9 first select after reset captures", {dout_en, dout}, {1'b1, 4'hA});
    step(1, 1, 4'h0, 4'h0);
  endtask

  initial begin
    sel_n = 1'b1; wr_n = 1'b1; addr_in = '0; din = '0; rst = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_addr_hold();
    t_no_relatch();
    t_rewrite();
    t_rmw();
    t_reset_reopen();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule